// File: doc/BRIEF.md
# Dual-Window Pulse Shape Integrator

This block takes the baseline-corrected sample stream of one detector event and, using the constant-fraction timing index found earlier in the chain, sums the samples that fall in two windows. Each window begins a programmable number of samples after that timing index and covers a programmable number of samples. One window is short and covers the prompt part of the pulse. The other is long and covers the tail. When the event ends, the block divides the long sum by the short sum. The resulting fixed-point ratio is the pulse-shape figure that separates neutron events from gamma events.

An event begins with a one-cycle `start` pulse. That pulse latches the timing index, both window placements and the event length. The block then numbers each accepted sample from zero. After the last sample of the event, a serial restoring divider produces the ratio. Both sums, the ratio, a truncation flag and a divide-error flag are then presented, together with a one-cycle `res_valid` strobe. Samples need no smoothing. Events may be up to 1024 samples long.

Top module: `pulse_shape_integrator`

## Requirements
- R1: After reset, `res_valid`, `short_sum`, `long_sum`, `ratio`, `trunc_flag` and `div_err` are all zero.
- R2: A sample presented in the same cycle as `start` is ignored, and so is any sample presented while no event is open. The first sample with `smp_valid` high after `start` has index 0.
- R3: `short_sum` is the exact signed sum of the samples whose index i satisfies cfd+short_off <= i < cfd+short_off+short_len.
- R4: `long_sum` is the exact signed sum of the samples whose index i satisfies cfd+long_off <= i < cfd+long_off+long_len.
- R5: The sums never overflow, even for 1024 samples at either full-scale extreme (-32768 or +32767 for 16-bit samples).
- R6: `trunc_flag` is 1 when either window's end (cfd+off+len) exceeds `evt_len`. In that case only the samples inside the event are summed.
- R7: When `short_sum` > 0, `ratio` = floor(max(long_sum,0)*256 / short_sum), which is unsigned with 8 fractional bits. The result saturates to all ones (0xFFFF) when it does not fit, and `div_err` is 0.
- R8: When `short_sum` <= 0, `ratio` is all ones and `div_err` is 1.
- R9: `res_valid` is a one-cycle pulse. For a divided result it rises 35 clock edges after the edge that takes the last sample (NUM_W+2 with default parameters). For a divide error it rises 1 edge after that edge.
- R10: A `start` during an open event discards the partial sums and opens a new event.
- R11: Changing the window, index or length inputs after `start` has no effect on the running event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Opens an event and latches the configuration |
| cfd_idx | input | IDX_W | Timing index of the event |
| short_off | input | IDX_W | Short window start offset from the timing index |
| short_len | input | IDX_W+1 | Short window length in samples |
| long_off | input | IDX_W | Long window start offset from the timing index |
| long_len | input | IDX_W+1 | Long window length in samples |
| evt_len | input | IDX_W+1 | Number of samples in the event (1..2^IDX_W) |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | SAMPLE_W | Signed baseline-corrected sample |
| res_valid | output | 1 | One-cycle result strobe |
| short_sum | output | SAMPLE_W+IDX_W | Signed short-window integral |
| long_sum | output | SAMPLE_W+IDX_W | Signed long-window integral |
| ratio | output | RATIO_W | Long/short ratio with FRAC_W fractional bits |
| trunc_flag | output | 1 | A window ran past the event end |
| div_err | output | 1 | Short integral was zero or negative |

## Verification
Results are due at fixed distances from the clock edge that accepts the last sample. A divide error appears one edge later. A divided result appears 35 edges later: one edge to check the divisor, 33 divider steps and one edge to publish. When the bench drives the last sample, it loads a countdown with that distance. It checks `res_valid` on every clock, a few nanoseconds after the edge. The strobe must be high exactly when the countdown reaches zero and low on every other cycle. The sums, ratio and flags are compared against the bench's own model in that one cycle.

// File: rtl/pulse_shape_integrator.sv
module pulse_shape_integrator #(
  parameter int SAMPLE_W = 16,
  parameter int IDX_W    = 10,
  parameter int FRAC_W   = 8,
  parameter int RATIO_W  = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               start,
  input  logic [IDX_W-1:0]                   cfd_idx,
  input  logic [IDX_W-1:0]                   short_off,
  input  logic [IDX_W:0]                     short_len,
  input  logic [IDX_W-1:0]                   long_off,
  input  logic [IDX_W:0]                     long_len,
  input  logic [IDX_W:0]                     evt_len,
  input  logic                               smp_valid,
  input  logic signed [SAMPLE_W-1:0]         smp_data,
  output logic                               res_valid,
  output logic signed [SAMPLE_W+IDX_W-1:0]   short_sum,
  output logic signed [SAMPLE_W+IDX_W-1:0]   long_sum,
  output logic [RATIO_W-1:0]                 ratio,
  output logic                               trunc_flag,
  output logic                               div_err
);
  localparam int ACC_W  = SAMPLE_W + IDX_W;
  localparam int CNT_W  = IDX_W + 1;
  localparam int POS_W  = IDX_W + 2;
  localparam int NUM_W  = ACC_W - 1 + FRAC_W;
  localparam int STEP_W = $clog2(NUM_W);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_W - 1);

  typedef enum logic [2:0] {ST_IDLE, ST_ACC, ST_CHK, ST_DIV, ST_FIN} state_t;
  state_t st;

  logic [IDX_W-1:0]        cfd_q, soff_q, loff_q;
  logic [CNT_W-1:0]        slen_q, llen_q, elen_q, idx;
  logic signed [ACC_W-1:0] acc_s, acc_l;
  logic [ACC_W-2:0]        rem;
  logic [NUM_W-1:0]        quo;
  logic [STEP_W-1:0]       step;

  wire [POS_W-1:0] s_beg = POS_W'(cfd_q) + POS_W'(soff_q);
  wire [POS_W-1:0] s_end = s_beg + POS_W'(slen_q);
  wire [POS_W-1:0] l_beg = POS_W'(cfd_q) + POS_W'(loff_q);
  wire [POS_W-1:0] l_end = l_beg + POS_W'(llen_q);
  wire [POS_W-1:0] pos   = POS_W'(idx);
  wire hit_s    = (pos >= s_beg) && (pos < s_end);
  wire hit_l    = (pos >= l_beg) && (pos < l_end);
  wire last_smp = idx == elen_q - CNT_W'(1);
  wire trunc_c  = (s_end > POS_W'(elen_q)) || (l_end > POS_W'(elen_q));
  wire signed [ACC_W-1:0] smp_x = ACC_W'(smp_data);

  wire short_bad = acc_s[ACC_W-1] || (acc_s == '0);
  wire [NUM_W-1:0] dividend = acc_l[ACC_W-1] ? '0 : {acc_l[ACC_W-2:0], {FRAC_W{1'b0}}};
  wire [ACC_W-1:0] sh   = {rem, quo[NUM_W-1]};
  wire [ACC_W:0]   diff = {1'b0, sh} - {2'b0, acc_s[ACC_W-2:0]};
  wire             ge   = !diff[ACC_W];
  wire [RATIO_W-1:0] q_sat = (|quo[NUM_W-1:RATIO_W]) ? '1 : quo[RATIO_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      {cfd_q, soff_q, loff_q} <= '0;
      {slen_q, llen_q, elen_q, idx} <= '0;
      acc_s <= '0;
      acc_l <= '0;
      rem <= '0;
      quo <= '0;
      step <= '0;
      res_valid <= 1'b0;
      short_sum <= '0;
      long_sum <= '0;
      ratio <= '0;
      trunc_flag <= 1'b0;
      div_err <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      if (start) begin
        cfd_q  <= cfd_idx;
        soff_q <= short_off;
        loff_q <= long_off;
        slen_q <= short_len;
        llen_q <= long_len;
        elen_q <= evt_len;
        idx    <= '0;
        acc_s  <= '0;
        acc_l  <= '0;
        st     <= ST_ACC;
      end else begin
        case (st)
          ST_ACC: if (smp_valid) begin
            if (hit_s) acc_s <= acc_s + smp_x;
            if (hit_l) acc_l <= acc_l + smp_x;
            idx <= idx + CNT_W'(1);
            if (last_smp) st <= ST_CHK;
          end
          ST_CHK: if (short_bad) begin
            short_sum  <= acc_s;
            long_sum   <= acc_l;
            ratio      <= '1;
            div_err    <= 1'b1;
            trunc_flag <= trunc_c;
            res_valid  <= 1'b1;
            st         <= ST_IDLE;
          end else begin
            quo  <= dividend;
            rem  <= '0;
            step <= '0;
            st   <= ST_DIV;
          end
          ST_DIV: begin
            rem  <= ge ? diff[ACC_W-2:0] : sh[ACC_W-2:0];
            quo  <= {quo[NUM_W-2:0], ge};
            step <= step + STEP_W'(1);
            if (step == LAST_STEP) st <= ST_FIN;
          end
          ST_FIN: begin
            short_sum  <= acc_s;
            long_sum   <= acc_l;
            ratio      <= q_sat;
            div_err    <= 1'b0;
            trunc_flag <= trunc_c;
            res_valid  <= 1'b1;
            st         <= ST_IDLE;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  wire signed [63:0] r64     = $signed(64'(ratio));
  wire signed [63:0] s64     = 64'(short_sum);
  wire signed [63:0] chk_num = long_sum[ACC_W-1] ? 64'sd0 : (64'(long_sum) <<< FRAC_W);
  wire signed [63:0] chk_lo  = r64 * s64;
  wire signed [63:0] chk_hi  = (r64 + 64'sd1) * s64;

  a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  a_r8_err_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && div_err |-> (ratio == {RATIO_W{1'b1}}));
  a_r8_err_iff_nonpos: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (div_err == (short_sum[ACC_W-1] || short_sum == '0)));
  a_r7_ratio_floor: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !div_err |-> (chk_lo <= chk_num) && ((ratio == {RATIO_W{1'b1}}) || (chk_hi > chk_num)));
  a_r7_rem_fits: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DIV) && ge |-> !diff[ACC_W-1]);
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) && !start |=> $stable(acc_s) && $stable(acc_l));
endmodule

// File: tb/test_pulse_shape_integrator.sv
module test_pulse_shape_integrator;
  localparam int SW = 16, IW = 10, AW = 26, RW = 16, NUMW = 33;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0, smp_valid = 1'b0;
  logic [IW-1:0] cfd_idx = '0, short_off = '0, long_off = '0;
  logic [IW:0] short_len = '0, long_len = '0, evt_len = '0;
  logic signed [SW-1:0] smp_data = '0;
  logic res_valid, trunc_flag, div_err;
  logic signed [AW-1:0] short_sum, long_sum;
  logic [RW-1:0] ratio;

  pulse_shape_integrator i_pulse_shape_integrator (
    .clk(clk), .rst_n(rst_n), .start(start), .cfd_idx(cfd_idx),
    .short_off(short_off), .short_len(short_len), .long_off(long_off),
    .long_len(long_len), .evt_len(evt_len), .smp_valid(smp_valid),
    .smp_data(smp_data), .res_valid(res_valid), .short_sum(short_sum),
    .long_sum(long_sum), .ratio(ratio), .trunc_flag(trunc_flag), .div_err(div_err));

  int n_chk = 0, n_fail = 0, due = -1, cyc = 0;
  bit done = 1'b0;
  longint e_s, e_l, e_r;
  bit e_t, e_e;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint sval(input int pat, input int i);
    case (pat)
      0: return i * 7 - 50;
      1: return 1000 - i * 13;
      2: return -32768;
      3: return 32767;
      4: return (i % 5) * 100 + 3;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    #2;
    cyc++;
    if (!done && cyc > 150000) begin
      check(1'b0, "R9", "watchdog expired", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
    if (rst_n && !done) begin
      if (due > 0) due--;
      if (due == 0) begin
        check(res_valid == 1'b1, "R9", "res_valid when due", res_valid, 1);
        check(short_sum == e_s, "R3", "short_sum", short_sum, e_s);
        check(long_sum == e_l, "R4", "long_sum", long_sum, e_l);
        check(ratio == e_r, e_e ? "R8" : "R7", "ratio", ratio, e_r);
        check(div_err == e_e, "R8", "div_err", div_err, e_e);
        check(trunc_flag == e_t, "R6", "trunc_flag", trunc_flag, e_t);
        due = -1;
      end else begin
        check(res_valid == 1'b0, "R9", "res_valid outside due cycle", res_valid, 0);
      end
    end
  end

  task automatic partial(input int n);
    @(negedge clk);
    start = 1'b1; cfd_idx = 0; short_off = 0; short_len = 50;
    long_off = 0; long_len = 50; evt_len = 60; smp_valid = 1'b0;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < n; i++) begin
      smp_valid = 1'b1; smp_data = 16'sd9000;
      @(negedge clk);
    end
    smp_valid = 1'b0;
  endtask

  task automatic run_event(input int cfd, input int so, input int sl, input int lo,
                           input int ll, input int el, input int pat,
                           input bit gaps, input bit chg);
    longint s = 0, l = 0, num;
    int lat;
    for (int i = 0; i < el; i++) begin
      if (i >= cfd + so && i < cfd + so + sl) s += sval(pat, i);
      if (i >= cfd + lo && i < cfd + lo + ll) l += sval(pat, i);
    end
    e_s = s; e_l = l;
    e_t = (cfd + so + sl > el) || (cfd + lo + ll > el);
    if (s <= 0) begin
      e_e = 1'b1; e_r = 65535; lat = 2;
    end else begin
      e_e = 1'b0;
      num = (l < 0) ? 0 : l * 256;
      e_r = num / s;
      if (e_r > 65535) e_r = 65535;
      lat = NUMW + 3;
    end
    @(negedge clk);
    start = 1'b1; cfd_idx = IW'(cfd); short_off = IW'(so); short_len = (IW+1)'(sl);
    long_off = IW'(lo); long_len = (IW+1)'(ll); evt_len = (IW+1)'(el);
    smp_valid = 1'b1; smp_data = 16'sd12345;  // R2: ignored, same cycle as start
    @(negedge clk);
    start = 1'b0; smp_valid = 1'b0;
    if (chg) begin  // R11: late changes must not matter
      cfd_idx = 3; short_off = 1; short_len = 2; long_off = 1; long_len = 2; evt_len = 5;
    end
    for (int i = 0; i < el; i++) begin
      if (gaps && (i % 3 == 1)) begin
        smp_valid = 1'b0; smp_data = 16'sh7fff;
        @(negedge clk);
      end
      smp_valid = 1'b1; smp_data = SW'(sval(pat, i));
      if (i == el - 1) due = lat;
      @(negedge clk);
    end
    smp_valid = 1'b0;
    while (due != -1) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(res_valid == 0, "R1", "reset res_valid", res_valid, 0);
    check(short_sum == 0 && long_sum == 0, "R1", "reset sums", short_sum, 0);
    check(ratio == 0, "R1", "reset ratio", ratio, 0);
    check(trunc_flag == 0 && div_err == 0, "R1", "reset flags", {trunc_flag, div_err}, 0);

    run_event(10, 2, 8, 2, 40, 64, 4, 1'b0, 1'b0);      // R3 R4 R7
    run_event(20, 0, 5, 5, 30, 100, 0, 1'b1, 1'b0);     // R2 gaps
    run_event(50, 3, 4, 3, 60, 80, 4, 1'b0, 1'b0);      // R6 truncation
    run_event(0, 0, 1024, 0, 1024, 1024, 2, 1'b0, 1'b0); // R5 R8 negative full scale
    run_event(0, 1023, 1, 0, 1024, 1024, 3, 1'b0, 1'b0); // R5 R7 saturation
    run_event(4, 2, 0, 0, 20, 30, 4, 1'b0, 1'b0);       // R8 empty short window
    run_event(8, 1, 6, 1, 25, 40, 0, 1'b0, 1'b1);       // R11
    partial(20);
    run_event(6, 0, 6, 0, 20, 32, 4, 1'b0, 1'b0);       // R10 restart
    for (int i = 0; i < 6; i++) begin                   // R2 idle samples
      @(negedge clk); smp_valid = 1'b1; smp_data = 16'sh4000;
    end
    @(negedge clk); smp_valid = 1'b0;
    run_event(5, 0, 4, 70, 30, 120, 1, 1'b0, 1'b0);     // R7 negative long clamps to 0

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule